// File: doc/BRIEF.md
# Function-Coded ALU with Shared Adder

This block is a purely combinational arithmetic and logic unit of parameterised width (32 bits by default). A 3-bit function code chooses the operation applied to two operands, `a_i` and `b_i`. The available operations are bitwise AND, bitwise OR, addition, subtraction and signed set-less-than. A single adder serves addition, subtraction and set-less-than.

The top bit of the function code controls the second operand. When it is set, the operand is inverted before it reaches either the logic gates or the adder, and the same bit is fed to the adder as its carry-in. This gives A + ~B + 1, which is A − B. The low two bits of the code then pick one of four candidates for the result: the AND, the OR, the sum, or the sign bit of the sum padded with zeros.

A separate flag reports when the result is all zeros. A branch unit can use this flag directly as an equality test after a subtraction.

Top module: `shared_adder_alu`

## Requirements
- R1: When fn_i[2] is 1, the bitwise complement of b_i replaces b_i in every operation. Code 3'b100 yields a_i & ~b_i.
- R2: Code 3'b000 yields a_i & b_i.
- R3: Code 3'b001 yields a_i | b_i, and code 3'b101 yields a_i | ~b_i.
- R4: Code 3'b010 yields a_i + b_i modulo 2^WIDTH.
- R5: Code 3'b110 yields a_i − b_i modulo 2^WIDTH. The inverted operand plus a carry-in of 1 produces this result.
- R6: Code 3'b111 yields, in bit 0, the most significant bit of the modulo difference a_i − b_i. All other bits are 0. Overflow is not corrected, so the bit can disagree with a true signed comparison.
- R7: Code 3'b011 yields all zeros for any operands.
- R8: zero_o is 1 exactly when y_o is all zeros.
- R9: y_o and zero_o follow the inputs with no clock and no storage. They are valid in the same cycle the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand, inverted when fn_i[2] is 1 |
| fn_i | input | 3 | Function code |
| y_o | output | WIDTH | Result |
| zero_o | output | 1 | High when y_o is all zeros |

## Verification
Both results are combinational, so they are due in the same cycle the operands and code are applied. The driver changes the inputs just after a rising edge and pushes the expected result and flag into a queue. The monitor pops each item and compares it half a period later, on the falling edge, so every comparison sees settled values. The operands cover zero, all ones, the most negative value and random values. They also include two set-less-than cases in which overflow flips the sign of the difference.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned FN_W = 3;

  typedef enum logic [FN_W-1:0] {
    FN_AND  = 3'b000,
    FN_OR   = 3'b001,
    FN_ADD  = 3'b010,
    FN_RSVD = 3'b011,
    FN_ANDN = 3'b100,
    FN_ORN  = 3'b101,
    FN_SUB  = 3'b110,
    FN_SLT  = 3'b111
  } alu_fn_e;

  typedef enum logic [1:0] {
    SEL_AND = 2'b00,
    SEL_OR  = 2'b01,
    SEL_SUM = 2'b10,
    SEL_SGN = 2'b11
  } alu_sel_e;
endpackage

// File: rtl/alu_operand.sv
module alu_operand #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] b_i,
  input  logic             inv_i,
  output logic [WIDTH-1:0] b_o
);
  assign b_o = b_i ^ {WIDTH{inv_i}};
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o
);
  assign sum_o = a_i + b_i + {{(WIDTH-1){1'b0}}, cin_i};
endmodule

// File: rtl/alu_out_sel.sv
module alu_out_sel
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] sum_i,
  input  logic             inv_i,
  input  alu_sel_e         sel_i,
  output logic [WIDTH-1:0] y_o
);
  always_comb begin
    unique case (sel_i)
      SEL_AND: y_o = a_i & b_i;
      SEL_OR:  y_o = a_i | b_i;
      SEL_SUM: y_o = sum_i;
      // sign bit only valid with inverted operand; otherwise reserved code
      SEL_SGN: y_o = inv_i ? {{(WIDTH-1){1'b0}}, sum_i[WIDTH-1]} : '0;
      default: y_o = '0;
    endcase
  end

  always_comb begin
    if (sel_i == SEL_SGN && !inv_i)
      a_r7_rsvd_zero: assert (y_o == '0) else $error("R7 reserved code nonzero");
    if (sel_i == SEL_SGN && inv_i)
      a_r6_slt_upper_zero: assert (y_o[WIDTH-1:1] == '0) else $error("R6 slt upper bits set");
  end
endmodule

// File: rtl/shared_adder_alu.sv
module shared_adder_alu
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       fn_i,
  output logic [WIDTH-1:0] y_o,
  output logic             zero_o
);
  logic             inv;
  alu_sel_e         sel;
  logic [WIDTH-1:0] b_op;
  logic [WIDTH-1:0] sum;

  assign inv = fn_i[2];
  assign sel = alu_sel_e'(fn_i[1:0]);

  alu_operand #(.WIDTH(WIDTH)) i_operand (
    .b_i   (b_i),
    .inv_i (inv),
    .b_o   (b_op)
  );

  // carry-in tied to the invert bit: A + ~B + 1
  alu_adder #(.WIDTH(WIDTH)) i_adder (
    .a_i   (a_i),
    .b_i   (b_op),
    .cin_i (inv),
    .sum_o (sum)
  );

  alu_out_sel #(.WIDTH(WIDTH)) i_out_sel (
    .a_i   (a_i),
    .b_i   (b_op),
    .sum_i (sum),
    .inv_i (inv),
    .sel_i (sel),
    .y_o   (y_o)
  );

  assign zero_o = ~|y_o;

  always_comb begin
    if (fn_i == FN_SUB)
      a_r5_sub_diff: assert (y_o == a_i - b_i) else $error("R5 sub mismatch");
    if (fn_i == FN_ANDN)
      a_r1_andn: assert (y_o == (a_i & ~b_i)) else $error("R1 andn mismatch");
    if (fn_i == FN_ADD)
      a_r4_add_sum: assert (y_o == a_i + b_i) else $error("R4 add mismatch");
    a_r8_zero_flag: assert (zero_o == (y_o == '0)) else $error("R8 zero flag mismatch");
  end
endmodule

// File: tb/test_shared_adder_alu.sv
module test_shared_adder_alu;
  localparam int unsigned WIDTH      = 32;
  localparam time         CLK_PERIOD = 10ns;
  localparam logic [WIDTH-1:0] ONES = '1;
  localparam logic [WIDTH-1:0] MNEG = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] MPOS = {1'b0, {(WIDTH-1){1'b1}}};

  typedef struct {
    logic [WIDTH-1:0] y;
    logic             z;
    logic [2:0]       fn;
    string            req;
  } exp_t;

  logic             clk = 1'b0;
  logic [WIDTH-1:0] a, b, y;
  logic [2:0]       fn;
  logic             zero;
  int               checks = 0;
  int               errors = 0;
  bit               done = 1'b0;
  exp_t             q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  shared_adder_alu #(.WIDTH(WIDTH)) i_shared_adder_alu (
    .a_i(a), .b_i(b), .fn_i(fn), .y_o(y), .zero_o(zero)
  );

  function automatic string req_of(logic [2:0] f);
    case (f)
      3'b000: return "R2";
      3'b001: return "R3";
      3'b010: return "R4";
      3'b011: return "R7";
      3'b100: return "R1";
      3'b101: return "R3";
      3'b110: return "R5";
      default: return "R6";
    endcase
  endfunction

  // reference built from the requirement text
  function automatic logic [WIDTH-1:0] ref_y(logic [2:0] f, logic [WIDTH-1:0] ra, logic [WIDTH-1:0] rb);
    logic [WIDTH-1:0] d;
    d = ra - rb;
    case (f)
      3'b000: return ra & rb;
      3'b001: return ra | rb;
      3'b010: return ra + rb;
      3'b011: return '0;
      3'b100: return ra & ~rb;
      3'b101: return ra | ~rb;
      3'b110: return d;
      default: return {{(WIDTH-1){1'b0}}, d[WIDTH-1]};
    endcase
  endfunction

  task automatic drive(input logic [2:0] f, input logic [WIDTH-1:0] da, input logic [WIDTH-1:0] db,
                       input string tag = "");
    exp_t e;
    @(posedge clk);
    #1;
    a = da; b = db; fn = f;
    e.y = ref_y(f, da, db);
    e.z = (e.y == '0);
    e.fn = f;
    e.req = (tag != "") ? tag : req_of(f);
    q.push_back(e);
  endtask

  // monitor: results due same cycle (R9), compared half a period after drive
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (y !== e.y) begin
        errors++;
        $display("FAIL %s/R9 fn=%b y actual=%h expected=%h", e.req, e.fn, y, e.y);
      end
      checks++;
      if (zero !== e.z) begin
        errors++;
        $display("FAIL R8 fn=%b zero actual=%b expected=%b", e.fn, zero, e.z);
      end
    end
  end

  initial begin
    a = '0; b = '0; fn = 3'b000;
    // initial state: zero operands, AND -> result 0, flag 1 (R2, R8)
    drive(3'b000, '0, '0, "R2");
    for (int f = 0; f < 8; f++) begin
      drive(3'(f), '0, '0);
      drive(3'(f), ONES, ONES);
      drive(3'(f), MNEG, 32'h1);
      drive(3'(f), ONES, '0);
      drive(3'(f), 32'h1234_5678, 32'h1234_5678);
      for (int k = 0; k < 12; k++) drive(3'(f), $urandom(), $urandom());
    end
    // R6 overflow: MPOS - (-1) wraps to MNEG, bit is 1 though a > b signed
    drive(3'b111, MPOS, ONES, "R6");
    // R6 overflow: MNEG - 1 wraps to MPOS, bit is 0 though a < b signed
    drive(3'b111, MNEG, 32'h1, "R6");
    drive(3'b111, 32'h5, 32'h7, "R6");
    drive(3'b010, ONES, 32'h1, "R4");   // wrap to zero, flag set
    drive(3'b110, 32'h9, 32'h9, "R5");  // equal operands -> zero flag
    drive(3'b011, ONES, 32'hA5A5_A5A5, "R7");
    drive(3'b100, ONES, ONES, "R1");
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule